// File: doc/BRIEF.md
# Nibble-Handshake Packet Receiver

This block receives packets from a peer that sends bytes four bits at a time over a parallel link. The link has four data lines and one handshake line in each direction. For each byte, the peer first places the upper nibble and raises its handshake line. The receiver stores that nibble and raises its own handshake line in answer. The peer then places the lower nibble and drops its handshake. The receiver joins the two nibbles into a byte and drops its own handshake. The peer marks the end of a packet by driving the complement of the last nibble onto the data lines while leaving its handshake line where it was.

Every packet must begin with the fixed byte pair 0x08, 0x00. The receiver checks this pair and removes it. Payload bytes leave on a valid/ready byte stream that carries a last flag. One-cycle pulses report a packet that completed normally and a packet whose header was bad.

All five inputs pass through a two-flop synchronizer. They are then held back until the whole five-bit vector has stayed unchanged for a configurable number of cycles, so that skew between the lines is not mistaken for a transition.

Back-pressure rules for the stream:
- A byte is transferred on each clock edge where `m_valid` and `m_ready` are both high.
- While `m_valid` is high and `m_ready` is low, the byte and its flag stay unchanged.
- When the output register and the one-byte holding slot are both occupied, the receiver keeps `hs_out` high and does not acknowledge the lower nibble. This throttles the peer.

Top module: `nib_pkt_rx`

## Requirements
- R1: A rising edge on the filtered `hs_in` captures `nib_in` as the upper nibble, and `hs_out` then rises.
- R2: A falling edge on the filtered `hs_in` captures `nib_in` as the lower nibble and forms the byte {upper, lower}; `hs_out` then falls.
- R3: During a packet, `nib_in` becoming the bitwise complement of the most recently captured nibble while `hs_in` holds its level ends the packet. A lower nibble that equals the complement of the upper nibble, arriving together with the `hs_in` fall, is an ordinary byte (for example 0x5A).
- R4: The first byte must be 0x08 and the second 0x00. Neither appears on the output; every later byte is output in order.
- R5: Either of two faults produces a single one-cycle `hdr_err` pulse: a header byte that does not match, or a packet that ends before both header bytes have arrived. In both cases nothing from that packet is output and `pkt_done` does not pulse.
- R6: `m_last` is set only on the final payload byte before the end marker. `pkt_done` pulses once for each packet with a correct header, and this includes a packet with no payload.
- R7: While `m_valid` is high and `m_ready` is low, `m_data` and `m_last` hold their values and no byte is lost. When storage is full, `hs_out` stays high until room appears.
- R8: If `hs_out` has been high TMO_CYC cycles waiting for the `hs_in` fall, the block returns to idle and lowers `hs_out`. It discards the partial packet and raises neither status pulse.
- R9: An input change that lasts fewer cycles than the stability window is ignored. In idle, data-line changes without an `hs_in` rise are ignored as well.
- R10: After reset, `hs_out`, `m_valid`, `pkt_done` and `hdr_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nib_in | input | 4 | Data lines from the peer |
| hs_in | input | 1 | Handshake line from the peer |
| hs_out | output | 1 | Acknowledge handshake to the peer |
| m_data | output | 8 | Payload byte |
| m_valid | output | 1 | Payload byte valid |
| m_ready | input | 1 | Downstream can accept a byte |
| m_last | output | 1 | Final payload byte of the packet |
| pkt_done | output | 1 | One-cycle pulse: packet completed with a good header |
| hdr_err | output | 1 | One-cycle pulse: header mismatch or truncated header |

## Verification
Directed packets carry bytes whose lower nibble is the complement of the upper one (0x5A, 0xA5, 0xF0, 0x0F). These show whether the end detector correctly requires `hs_in` to hold its level, or whether it fires on a normal nibble exchange. Further directed cases cover:
- a header-only packet, which checks the completion pulse when there is no payload;
- a bad first header byte, a bad second header byte, and a truncated header, which test how errors are classified;
- a one-cycle handshake glitch, which tests the input filter;
- a stalled peer, which tests the timeout.

Seeded random packets, with random lengths and a random `m_ready`, check byte order and last-flag placement while back-pressure stalls the acknowledge.

// File: rtl/nib_rx_pkg.sv
package nib_rx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_HI,
    S_PUSH,
    S_LO,
    S_FLUSH
  } rx_state_t;

  localparam logic [7:0] HDR_B0 = 8'h08;
  localparam logic [7:0] HDR_B1 = 8'h00;
endpackage

// File: rtl/nib_rx_filter.sv
module nib_rx_filter #(
  parameter int W          = 5,
  parameter int STABLE_CYC = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] clean
);
  localparam int CW = $clog2(STABLE_CYC + 1);

  logic [W-1:0] s1, s2, cand;
  logic [CW-1:0] cnt;

  // two-flop synchronizer per line
  for (genvar i = 0; i < W; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[i] <= 1'b0;
        s2[i] <= 1'b0;
      end else begin
        s1[i] <= raw[i];
        s2[i] <= s1[i];
      end
    end
  end

  // whole-vector stability window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand  <= '0;
      cnt   <= '0;
      clean <= '0;
    end else if (s2 != cand) begin
      cand <= s2;
      cnt  <= '0;
    end else if (cnt != CW'(STABLE_CYC)) begin
      cnt <= cnt + 1'b1;
    end else begin
      clean <= cand;
    end
  end
endmodule

// File: rtl/nib_rx_ostage.sv
module nib_rx_ostage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] push_d,
  input  logic       push_last,
  input  logic       m_ready,
  output logic [7:0] m_data,
  output logic       m_valid,
  output logic       m_last,
  output logic       free
);
  assign free = !m_valid || m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_last  <= 1'b0;
    end else if (push) begin
      m_valid <= 1'b1;
      m_data  <= push_d;
      m_last  <= push_last;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  a_r7_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!m_valid || m_ready));
endmodule

// File: rtl/nib_rx_fsm.sv
module nib_rx_fsm
  import nib_rx_pkg::*;
#(
  parameter int TMO_CYC = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] f_d,
  input  logic       f_hs,
  input  logic       slot_free,
  output logic       hs_out,
  output logic       push,
  output logic [7:0] push_d,
  output logic       push_last,
  output logic       pkt_done,
  output logic       hdr_err
);
  localparam int TW = $clog2(TMO_CYC + 1);

  rx_state_t state;
  logic [3:0] nib_hi, nib_lo;
  logic [1:0] hdr_cnt;
  logic       drop, pend_v, hs_prev;
  logic [7:0] pend_d;
  logic [TW-1:0] tmo_cnt;

  logic rise, fall, steady, tmo_hit, end_hit, payload_in;
  logic [7:0] byte_w, hdr_exp;

  assign rise    = f_hs && !hs_prev;
  assign fall    = !f_hs && hs_prev;
  assign steady  = (f_hs == hs_prev);
  assign tmo_hit = (state == S_HI) && (tmo_cnt == TW'(TMO_CYC - 1));
  assign byte_w  = {nib_hi, f_d};
  assign hdr_exp = (hdr_cnt == 2'd0) ? HDR_B0 : HDR_B1;
  assign end_hit = ((state == S_HI) && steady && !tmo_hit && (f_d == ~nib_hi)) ||
                   ((state == S_LO) && steady && (f_d == ~nib_lo));
  assign payload_in = (state == S_HI) && fall && !tmo_hit && !drop && (hdr_cnt == 2'd2);
  assign hs_out = (state == S_HI) || (state == S_PUSH);

  always_comb begin
    push      = 1'b0;
    push_d    = pend_d;
    push_last = 1'b0;
    case (state)
      S_HI:    push = payload_in && pend_v && slot_free;
      S_PUSH:  push = slot_free;
      S_FLUSH: begin
        push      = slot_free;
        push_last = 1'b1;
      end
      default: push = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      nib_hi   <= '0;
      nib_lo   <= '0;
      hdr_cnt  <= '0;
      drop     <= 1'b0;
      pend_v   <= 1'b0;
      pend_d   <= '0;
      hs_prev  <= 1'b0;
      tmo_cnt  <= '0;
      pkt_done <= 1'b0;
      hdr_err  <= 1'b0;
    end else begin
      hs_prev  <= f_hs;
      pkt_done <= 1'b0;
      hdr_err  <= 1'b0;
      if (end_hit) begin
        if (drop) begin
          state <= S_IDLE;
        end else if (hdr_cnt != 2'd2) begin
          hdr_err <= 1'b1;
          state   <= S_IDLE;
        end else if (pend_v) begin
          state <= S_FLUSH;
        end else begin
          pkt_done <= 1'b1;
          state    <= S_IDLE;
        end
      end else begin
        case (state)
          S_IDLE: if (rise) begin
            nib_hi  <= f_d;
            hdr_cnt <= '0;
            drop    <= 1'b0;
            pend_v  <= 1'b0;
            tmo_cnt <= '0;
            state   <= S_HI;
          end
          S_HI: begin
            tmo_cnt <= tmo_cnt + 1'b1;
            if (tmo_hit) begin
              pend_v <= 1'b0;
              state  <= S_IDLE;
            end else if (fall) begin
              nib_lo <= f_d;
              state  <= S_LO;
              if (!drop) begin
                if (hdr_cnt != 2'd2) begin
                  if (byte_w != hdr_exp) begin
                    hdr_err <= 1'b1;
                    drop    <= 1'b1;
                  end else begin
                    hdr_cnt <= hdr_cnt + 1'b1;
                  end
                end else if (pend_v && !slot_free) begin
                  state <= S_PUSH;
                end else begin
                  pend_d <= byte_w;
                  pend_v <= 1'b1;
                end
              end
            end
          end
          S_PUSH: if (slot_free) begin
            pend_d <= {nib_hi, nib_lo};
            state  <= S_LO;
          end
          S_LO: if (rise) begin
            nib_hi  <= f_d;
            tmo_cnt <= '0;
            state   <= S_HI;
          end
          S_FLUSH: if (slot_free) begin
            pend_v   <= 1'b0;
            pkt_done <= 1'b1;
            state    <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  a_r1_ack_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_out) |-> $past(f_hs));

  a_r5_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_done && hdr_err));

  a_r6_done_with_last: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_last) |=> pkt_done);

  a_r8_timeout_drops_ack: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> !hs_out);
endmodule

// File: rtl/nib_pkt_rx.sv
module nib_pkt_rx #(
  parameter int STABLE_CYC = 3,
  parameter int TMO_CYC    = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] nib_in,
  input  logic       hs_in,
  output logic       hs_out,
  output logic [7:0] m_data,
  output logic       m_valid,
  input  logic       m_ready,
  output logic       m_last,
  output logic       pkt_done,
  output logic       hdr_err
);
  localparam int LINES = 5;

  logic [LINES-1:0] clean;
  logic       slot_free, push, push_last;
  logic [7:0] push_d;

  nib_rx_filter #(.W(LINES), .STABLE_CYC(STABLE_CYC)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   ({hs_in, nib_in}),
    .clean (clean)
  );

  nib_rx_fsm #(.TMO_CYC(TMO_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .f_d       (clean[3:0]),
    .f_hs      (clean[4]),
    .slot_free (slot_free),
    .hs_out    (hs_out),
    .push      (push),
    .push_d    (push_d),
    .push_last (push_last),
    .pkt_done  (pkt_done),
    .hdr_err   (hdr_err)
  );

  nib_rx_ostage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_d    (push_d),
    .push_last (push_last),
    .m_ready   (m_ready),
    .m_data    (m_data),
    .m_valid   (m_valid),
    .m_last    (m_last),
    .free      (slot_free)
  );
endmodule

// File: tb/sim_nib_pkt_rx.sv
module sim_nib_pkt_rx;
  localparam int TMO = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] nib_in = '0;
  logic hs_in = 1'b0;
  logic m_ready = 1'b1;
  logic hs_out, m_valid, m_last, pkt_done, hdr_err;
  logic [7:0] m_data;

  always #2.5 clk = ~clk;

  nib_pkt_rx #(.STABLE_CYC(3), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .nib_in(nib_in), .hs_in(hs_in), .hs_out(hs_out),
    .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready), .m_last(m_last),
    .pkt_done(pkt_done), .hdr_err(hdr_err)
  );

  int tests = 0, fails = 0;
  int rx_n = 0, done_cnt = 0, err_cnt = 0, hs_hi_cnt = 0;
  bit rand_ready = 1'b0;
  logic [7:0] rx_d [0:63];
  logic       rx_l [0:63];
  logic [7:0] tx [0:63];
  int tx_len = 0;

  function automatic bit exp_last(int i, int n);
    return (i == n - 1);
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sink and monitors, away from the active edge
  always @(negedge clk) begin
    m_ready = rand_ready ? 1'($urandom % 2) : 1'b1;
    if (rst_n && m_valid && m_ready && rx_n < 64) begin
      rx_d[rx_n] = m_data;
      rx_l[rx_n] = m_last;
      rx_n++;
    end
    if (rst_n && pkt_done) done_cnt++;
    if (rst_n && hdr_err) err_cnt++;
    if (rst_n && hs_out) hs_hi_cnt++;
  end

  task automatic wait_hs(logic v, string req);
    int n = 0;
    while (hs_out !== v && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (hs_out !== v) begin
      tests++;
      fails++;
      $display("FAIL %s hs_out actual=%0b expected=%0b", req, hs_out, v);
    end
  endtask

  task automatic gap();
    repeat ($urandom % 4) @(negedge clk);
  endtask

  task automatic send_byte(logic [7:0] b);
    @(negedge clk);
    hs_in = 1'b1; nib_in = b[7:4];
    wait_hs(1'b1, "R1");
    gap();
    @(negedge clk);
    hs_in = 1'b0; nib_in = b[3:0];
    wait_hs(1'b0, "R2");
    gap();
  endtask

  task automatic end_mark();
    @(negedge clk);
    nib_in = ~nib_in;
    repeat (20) @(negedge clk);
    nib_in = '0;
  endtask

  task automatic clear_counts();
    rx_n = 0; done_cnt = 0; err_cnt = 0;
  endtask

  task automatic settle(int exp_n);
    int n = 0;
    while (rx_n < exp_n && n < 600) begin
      @(negedge clk);
      n++;
    end
    repeat (10) @(negedge clk);
  endtask

  // good packet from tx[0:tx_len-1], header prepended
  task automatic run_good(string tag);
    clear_counts();
    send_byte(8'h08);
    send_byte(8'h00);
    for (int i = 0; i < tx_len; i++) send_byte(tx[i]);
    end_mark();
    settle(tx_len);
    check({tag, " R4 byte count"}, rx_n, tx_len);
    for (int i = 0; i < tx_len && i < rx_n; i++) begin
      check({tag, " R4 data"}, int'(rx_d[i]), int'(tx[i]));
      check({tag, " R6 last flag"}, int'(rx_l[i]), int'(exp_last(i, tx_len)));
    end
    check({tag, " R6 pkt_done"}, done_cnt, 1);
    check({tag, " R5 no hdr_err"}, err_cnt, 0);
  endtask

  task automatic run_bad(logic [7:0] h0, logic [7:0] h1, int nbytes, string tag);
    clear_counts();
    send_byte(h0);
    if (nbytes > 1) send_byte(h1);
    for (int i = 2; i < nbytes; i++) send_byte(8'($urandom));
    end_mark();
    settle(0);
    check({tag, " R5 hdr_err"}, err_cnt, 1);
    check({tag, " R5 no output"}, rx_n, 0);
    check({tag, " R5 no pkt_done"}, done_cnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    check("R10 hs_out reset", int'(hs_out), 0);
    check("R10 m_valid reset", int'(m_valid), 0);
    check("R10 pkt_done reset", int'(pkt_done), 0);
    check("R10 hdr_err reset", int'(hdr_err), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9: one-cycle handshake glitch and data wiggle in idle
    hs_hi_cnt = 0;
    hs_in = 1'b1; @(negedge clk); hs_in = 1'b0;
    repeat (20) @(negedge clk);
    nib_in = 4'h5; repeat (20) @(negedge clk); nib_in = 4'h0;
    repeat (20) @(negedge clk);
    check("R9 glitch ignored", hs_hi_cnt, 0);
    check("R9 no output", rx_n, 0);

    // R3/R4/R6: complementary-nibble bytes
    tx_len = 6;
    tx[0] = 8'hF0; tx[1] = 8'h0F; tx[2] = 8'h5A;
    tx[3] = 8'hA5; tx[4] = 8'h00; tx[5] = 8'hFF;
    run_good("R3 dir");

    // R6: header only
    tx_len = 0;
    run_good("R6 empty");

    // R5: header faults
    run_bad(8'h09, 8'h00, 4, "bad first");
    run_bad(8'h08, 8'h01, 4, "bad second");
    run_bad(8'h08, 8'h00, 1, "truncated");

    // R8: stalled peer mid-byte
    clear_counts();
    @(negedge clk);
    hs_in = 1'b1; nib_in = 4'h3;
    wait_hs(1'b1, "R8");
    repeat (TMO + 50) @(negedge clk);
    check("R8 hs_out dropped", int'(hs_out), 0);
    hs_in = 1'b0; nib_in = 4'h0;
    repeat (30) @(negedge clk);
    check("R8 no pkt_done", done_cnt, 0);
    check("R8 no hdr_err", err_cnt, 0);
    check("R8 no output", rx_n, 0);
    tx_len = 2; tx[0] = 8'h3C; tx[1] = 8'hC3;
    run_good("R8 recover");

    // R7: random packets with random back-pressure
    rand_ready = 1'b1;
    for (int p = 0; p < 20; p++) begin
      tx_len = 1 + ($urandom % 16);
      for (int i = 0; i < tx_len; i++) tx[i] = 8'($urandom);
      run_good("R7 rand");
    end
    rand_ready = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule